// File: doc/BRIEF.md
# Reconfiguration-Aware Cell Module Shell

This block wraps a user processing slot that carries fixed-length cells on a 32-bit stream. Each cell is 14 words long; a start strobe marks the first word and the rest follow on back-to-back cycles. The shell registers every input and output at its edge, stores incoming cells in a small buffer of whole cells, and forwards each cell unchanged to its output port once the downstream side says it can take one. It tells the upstream side when a further whole cell would fit, and it counts (and discards) any cell whose start arrives while it has refused new cells.

The shell also handles the handshake that precedes a partial reconfiguration of its slot. After reset it waits for the active-low run enable, then raises its active-low quiet output before it admits any cell. When the run enable goes high, it stops admitting cells, lets any cell already being received finish, sends every buffered cell downstream, and only then drives the quiet output low. It then stays quiet until the next reset.

Top module: `cellShell`

## Requirements
- R1: In the first cycle after reset, quietN, inCellAvail, outSoc and dropCount are all 0.
- R2: With runEnN held low, quietN goes to 1 on the third rising edge after reset is released; inCellAvail is never 1 while quietN is 0.
- R3: An admitted cell leaves on outData as its 14 words in unchanged order on consecutive cycles, with outSoc high only on the first word; with downstream open and the buffer empty, outSoc rises on the 15th rising edge after the edge that captures the input start strobe.
- R4: Cells sent back to back (a start strobe on the cycle after the previous cell's last word) are all admitted and leave in arrival order with no drop.
- R5: An output cell starts only if outCellAvail was 1 two cycles before outSoc rises; while outCellAvail is 0, admitted cells are held (up to two whole cells) and none is sent.
- R6: inCellAvail is 0 while two whole cells are held or being received, and returns to 1 once space for a cell is free again.
- R7: A start strobe that arrives while the shell cannot admit a cell increments dropCount by one, and none of that cell's words ever appear at the output.
- R8: When runEnN rises in the middle of an incoming cell, that cell is completed and forwarded, and inCellAvail goes to 0.
- R9: After a reconfiguration request, quietN goes low exactly two rising edges after the edge that places the last word of the last held cell on outData, and stays low until reset.
- R10: Cells offered after a reconfiguration request produce no output and each increments dropCount.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for all ports |
| rstN | input | 1 | Synchronous reset, active low |
| runEnN | input | 1 | Low: operate; high: reconfiguration requested |
| quietN | output | 1 | High while operating; low once drained and safe to reconfigure |
| inSoc | input | 1 | Start of an incoming cell (first word) |
| inData | input | 32 | Incoming cell word |
| inCellAvail | output | 1 | Shell can admit a further whole cell |
| outSoc | output | 1 | Start of an outgoing cell (first word) |
| outData | output | 32 | Outgoing cell word |
| outCellAvail | input | 1 | Downstream can take a whole cell |
| dropCount | output | 8 | Saturating count of refused cells |

## Verification
The hardest situation to reach is a reconfiguration request that lands in the middle of an incoming cell, because the shell must then finish that cell, send it, and only afterwards report quiet. The bench runs the cell sender and a parallel thread that raises runEnN five words into the cell, then watches quietN each cycle and compares the edge where it falls with the edge that carried the cell's last output word. Refused cells are reached by closing the downstream side until two cells fill the buffer and then offering a third.

// File: rtl/cellShellPkg.sv
package cellShellPkg;

  // Strobes the control side hands to the datapath each cycle.
  typedef struct packed {
    logic wrEn;     // store the registered input word
    logic rdEn;     // move one buffered word to the output register
    logic rdFirst;  // the word being moved is the first of a cell
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_BOOT  = 2'd0,  // after reset, waiting for run enable
    ST_RUN   = 2'd1,  // admitting cells
    ST_DRAIN = 2'd2,  // request seen, emptying the buffer
    ST_QUIET = 2'd3   // empty, safe to reconfigure
  } shellState_t;

endpackage

// File: rtl/cellShellPath.sv
module cellShellPath
  import cellShellPkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int CELL_WORDS = 14,
  parameter int BUF_CELLS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inSoc,
  input  logic [WORD_W-1:0] inData,
  input  dpStrobe_t         strobe,
  output logic              socQ,
  output logic              outSoc,
  output logic [WORD_W-1:0] outData
);

  localparam int DEPTH = BUF_CELLS * CELL_WORDS;
  localparam int PTR_W = $clog2(DEPTH);

  logic [WORD_W-1:0] dataQ;
  logic [WORD_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;

  // boundary registers on the input side
  always_ff @(posedge clk) begin
    if (!rstN) begin
      socQ  <= 1'b0;
      dataQ <= '0;
    end else begin
      socQ  <= inSoc;
      dataQ <= inData;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn) store[wrPtr] <= dataQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      outSoc  <= 1'b0;
      outData <= '0;
    end else begin
      if (strobe.wrEn)
        wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (strobe.rdEn) begin
        rdPtr   <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
        outData <= store[rdPtr];
        outSoc  <= strobe.rdFirst;
      end else begin
        outData <= '0;
        outSoc  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cellShellCtrl.sv
module cellShellCtrl
  import cellShellPkg::*;
#(
  parameter int CELL_WORDS = 14,
  parameter int BUF_CELLS  = 2,
  parameter int ERR_W      = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEnN,
  input  logic             outCellAvail,
  input  logic             socQ,
  output dpStrobe_t        strobe,
  output logic             quietN,
  output logic             inCellAvail,
  output logic [ERR_W-1:0] dropCount
);

  localparam int CNT_W  = $clog2(CELL_WORDS);
  localparam int HELD_W = $clog2(BUF_CELLS + 1);

  shellState_t      state;
  logic             enQ;
  logic             availQ;
  logic             rxActive;
  logic             txActive;
  logic [CNT_W-1:0] rxCnt;
  logic [CNT_W-1:0] txCnt;
  logic [HELD_W-1:0] cellsHeld;   // cells occupying storage, incl. rx and tx
  logic [HELD_W-1:0] readyCells;  // complete cells not yet started out

  logic admit, startAcc, startRej, rxLast, txStart, txLast;

  always_comb begin
    admit    = (state == ST_RUN) && (cellsHeld < HELD_W'(BUF_CELLS));
    startAcc = socQ && !rxActive && admit;
    startRej = socQ && !rxActive && !admit;
    rxLast   = rxActive && (rxCnt == CNT_W'(CELL_WORDS - 1));
    txStart  = !txActive && (readyCells != '0) && availQ;
    txLast   = txActive && (txCnt == CNT_W'(CELL_WORDS - 1));
    strobe.wrEn    = startAcc || rxActive;
    strobe.rdEn    = txStart || txActive;
    strobe.rdFirst = txStart;
  end

  // boundary registers for control inputs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ    <= 1'b1;
      availQ <= 1'b0;
    end else begin
      enQ    <= runEnN;
      availQ <= outCellAvail;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_BOOT;
    end else begin
      case (state)
        ST_BOOT:  if (!enQ) state <= ST_RUN;
        ST_RUN:   if (enQ) state <= ST_DRAIN;
        ST_DRAIN: if (cellsHeld == '0) state <= ST_QUIET;
        default:  state <= ST_QUIET;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxActive <= 1'b0;
      rxCnt    <= '0;
    end else if (startAcc) begin
      rxActive <= 1'b1;
      rxCnt    <= CNT_W'(1);
    end else if (rxActive) begin
      rxActive <= !rxLast;
      rxCnt    <= rxLast ? '0 : rxCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txActive <= 1'b0;
      txCnt    <= '0;
    end else if (txStart) begin
      txActive <= 1'b1;
      txCnt    <= CNT_W'(1);
    end else if (txActive) begin
      txActive <= !txLast;
      txCnt    <= txLast ? '0 : txCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cellsHeld  <= '0;
      readyCells <= '0;
    end else begin
      if (startAcc && !txLast)      cellsHeld <= cellsHeld + 1'b1;
      else if (!startAcc && txLast) cellsHeld <= cellsHeld - 1'b1;
      if (rxLast && !txStart)       readyCells <= readyCells + 1'b1;
      else if (!rxLast && txStart)  readyCells <= readyCells - 1'b1;
    end
  end

  // boundary registers for control outputs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      quietN      <= 1'b0;
      inCellAvail <= 1'b0;
      dropCount   <= '0;
    end else begin
      quietN      <= (state == ST_RUN) || (state == ST_DRAIN);
      inCellAvail <= admit;
      if (startRej && (dropCount != '1)) dropCount <= dropCount + 1'b1;
    end
  end

endmodule

// File: rtl/cellShell.sv
module cellShell
  import cellShellPkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int CELL_WORDS = 14,
  parameter int BUF_CELLS  = 2,
  parameter int ERR_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEnN,
  output logic              quietN,
  input  logic              inSoc,
  input  logic [WORD_W-1:0] inData,
  output logic              inCellAvail,
  output logic              outSoc,
  output logic [WORD_W-1:0] outData,
  input  logic              outCellAvail,
  output logic [ERR_W-1:0]  dropCount
);

  dpStrobe_t strobe;
  logic      socQ;

  cellShellCtrl #(
    .CELL_WORDS(CELL_WORDS),
    .BUF_CELLS (BUF_CELLS),
    .ERR_W     (ERR_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .runEnN      (runEnN),
    .outCellAvail(outCellAvail),
    .socQ        (socQ),
    .strobe      (strobe),
    .quietN      (quietN),
    .inCellAvail (inCellAvail),
    .dropCount   (dropCount)
  );

  cellShellPath #(
    .WORD_W    (WORD_W),
    .CELL_WORDS(CELL_WORDS),
    .BUF_CELLS (BUF_CELLS)
  ) u_path (
    .clk    (clk),
    .rstN   (rstN),
    .inSoc  (inSoc),
    .inData (inData),
    .strobe (strobe),
    .socQ   (socQ),
    .outSoc (outSoc),
    .outData(outData)
  );

endmodule

// File: rtl/cellShellChk.sv
module cellShellChk #(
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             quietN,
  input logic             inCellAvail,
  input logic             outSoc,
  input logic             outCellAvail,
  input logic [ERR_W-1:0] dropCount
);

  // R2: admission is never offered while not operating
  a_r2_avail_needs_quietn: assert property (@(posedge clk) disable iff (!rstN)
    inCellAvail |-> quietN);

  // R3: a start strobe marks only the first word
  a_r3_single_soc: assert property (@(posedge clk) disable iff (!rstN)
    outSoc |=> !outSoc);

  // R5: downstream was open when the start decision was taken
  a_r5_avail_before_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outSoc) |-> $past(outCellAvail, 2));

  // R7: refused-cell count never goes down
  a_r7_drop_no_decrease: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> dropCount >= $past(dropCount));

  // R9: once quiet after operating, it stays quiet
  a_r9_quiet_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $fell(quietN) |=> !quietN);

  // R10: nothing leaves while quiet
  a_r10_no_output_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !quietN |-> !outSoc);

endmodule

bind cellShell cellShellChk #(.ERR_W(ERR_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .quietN      (quietN),
  .inCellAvail (inCellAvail),
  .outSoc      (outSoc),
  .outCellAvail(outCellAvail),
  .dropCount   (dropCount)
);

// File: tb/test_cellShell.sv
module test_cellShell;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runEnN = 1'b0;
  logic        inSoc = 1'b0;
  logic [31:0] inData = '0;
  logic        outCellAvail = 1'b1;
  logic        quietN;
  logic        inCellAvail;
  logic        outSoc;
  logic [31:0] outData;
  logic [7:0]  dropCount;

  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;

  logic [31:0] rxWords [32][14];
  int rxSocCyc [32];
  int rxLastCyc [32];
  int nCells = 0;
  int wIdx = 14;

  cellShell i_cellShell (
    .clk(clk), .rstN(rstN), .runEnN(runEnN), .quietN(quietN),
    .inSoc(inSoc), .inData(inData), .inCellAvail(inCellAvail),
    .outSoc(outSoc), .outData(outData), .outCellAvail(outCellAvail),
    .dropCount(dropCount)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // output monitor: collects whole cells
  always @(negedge clk) begin
    if (rstN && nCells < 32) begin
      if (outSoc) begin
        rxSocCyc[nCells] = cyc;
        rxWords[nCells][0] = outData;
        wIdx = 1;
      end else if (wIdx < 14) begin
        rxWords[nCells][wIdx] = outData;
        if (wIdx == 13) begin
          rxLastCyc[nCells] = cyc;
          nCells = nCells + 1;
        end
        wIdx = wIdx + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendCell(input logic [31:0] base, output int drvCyc);
    drvCyc = cyc;
    for (int i = 0; i < 14; i++) begin
      inSoc  = (i == 0);
      inData = base + 32'(i);
      @(negedge clk);
    end
    inSoc  = 1'b0;
    inData = '0;
  endtask

  task automatic checkCell(input int idx, input logic [31:0] base, input string req);
    int bad = 0;
    for (int i = 0; i < 14; i++)
      if (rxWords[idx][i] !== base + 32'(i)) bad++;
    check(bad == 0, req, "cell words mismatching", 32'(bad), 0);
  endtask

  task automatic testReset;
    rstN = 1'b0;
    runEnN = 1'b0;
    waitN(2);
    rstN = 1'b1;
    waitN(1);
    check(quietN == 1'b0, "R1", "quietN after reset", 32'(quietN), 0);
    check(inCellAvail == 1'b0, "R1", "inCellAvail after reset", 32'(inCellAvail), 0);
    check(outSoc == 1'b0, "R1", "outSoc after reset", 32'(outSoc), 0);
    check(dropCount == 8'd0, "R1", "dropCount after reset", 32'(dropCount), 0);
    waitN(1);
    check(quietN == 1'b0, "R2", "quietN at second edge", 32'(quietN), 0);
    waitN(1);
    check(quietN == 1'b1, "R2", "quietN at third edge", 32'(quietN), 1);
    check(inCellAvail == 1'b1, "R2", "inCellAvail when running", 32'(inCellAvail), 1);
  endtask

  task automatic testSingle;
    int drv;
    int n0 = nCells;
    sendCell(32'h1000_0000, drv);
    waitN(25);
    check(nCells == n0 + 1, "R3", "cells out", 32'(nCells), 32'(n0 + 1));
    checkCell(n0, 32'h1000_0000, "R3");
    check(rxSocCyc[n0] - (drv + 1) == 15, "R3", "latency edges",
          32'(rxSocCyc[n0] - (drv + 1)), 15);
  endtask

  task automatic testBackToBack;
    int drv;
    int n0 = nCells;
    sendCell(32'h2000_0000, drv);
    sendCell(32'h2100_0000, drv);
    sendCell(32'h2200_0000, drv);
    waitN(50);
    check(nCells == n0 + 3, "R4", "cells out", 32'(nCells), 32'(n0 + 3));
    checkCell(n0,     32'h2000_0000, "R4");
    checkCell(n0 + 1, 32'h2100_0000, "R4");
    checkCell(n0 + 2, 32'h2200_0000, "R4");
    check(dropCount == 8'd0, "R4", "no drops", 32'(dropCount), 0);
  endtask

  task automatic testBackpressure;
    int drv;
    int n0;
    logic [7:0] d0;
    outCellAvail = 1'b0;
    waitN(3);
    n0 = nCells;
    sendCell(32'h3000_0000, drv);
    sendCell(32'h3100_0000, drv);
    waitN(20);
    check(nCells == n0, "R5", "held while blocked", 32'(nCells), 32'(n0));
    check(inCellAvail == 1'b0, "R6", "inCellAvail when full", 32'(inCellAvail), 0);
    d0 = dropCount;
    sendCell(32'h3200_0000, drv);
    waitN(3);
    check(dropCount == d0 + 8'd1, "R7", "refused start counted",
          32'(dropCount), 32'(d0 + 8'd1));
    outCellAvail = 1'b1;
    waitN(50);
    check(nCells == n0 + 2, "R7", "dropped cell absent", 32'(nCells), 32'(n0 + 2));
    checkCell(n0,     32'h3000_0000, "R5");
    checkCell(n0 + 1, 32'h3100_0000, "R5");
    check(inCellAvail == 1'b1, "R6", "inCellAvail after release", 32'(inCellAvail), 1);
  endtask

  task automatic testReconfig;
    int drv;
    int fallCyc = -1;
    int n0 = nCells;
    logic [7:0] d0 = dropCount;
    outCellAvail = 1'b1;
    fork
      sendCell(32'h4000_0000, drv);
      begin
        waitN(5);
        runEnN = 1'b1;
      end
    join
    check(inCellAvail == 1'b0, "R8", "inCellAvail after request", 32'(inCellAvail), 0);
    check(quietN == 1'b1, "R9", "quietN while draining", 32'(quietN), 1);
    for (int i = 0; i < 60; i++) begin
      waitN(1);
      if (!quietN) begin
        fallCyc = cyc;
        break;
      end
    end
    check(nCells == n0 + 1, "R8", "started cell forwarded", 32'(nCells), 32'(n0 + 1));
    checkCell(n0, 32'h4000_0000, "R8");
    check(fallCyc - rxLastCyc[n0] == 2, "R9", "quietN fall after last word",
          32'(fallCyc - rxLastCyc[n0]), 2);
    sendCell(32'h5000_0000, drv);
    waitN(20);
    check(nCells == n0 + 1, "R10", "no output when quiet", 32'(nCells), 32'(n0 + 1));
    check(dropCount == d0 + 8'd1, "R10", "late cell counted",
          32'(dropCount), 32'(d0 + 8'd1));
    check(quietN == 1'b0, "R9", "quietN stays low", 32'(quietN), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    testReset();
    testSingle();
    testBackToBack();
    testBackpressure();
    testReconfig();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule